// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block reads a linked list of 16-byte transfer descriptors from memory and turns each one into a single burst request for a downstream data mover. A sequencer hands it a start pointer with a one-cycle start pulse. The walker fetches the descriptor's four 32-bit words one at a time over a simple read port, decodes them, and presents the burst: buffer address, length in 8-byte units, direction, an ordering hint and a 4-bit transfer mode. It then follows the descriptor's own next pointer. The walk ends after the descriptor that carries the last flag.

The sequencer sees `busy_o` while a walk is running and a one-cycle `done_o` when it ends. `err_o` gives the outcome and holds its value until the next accepted start. The walk is aborted with an error in two cases: a pointer that is not 8-byte aligned, or a chain that runs past the entry limit without ending, which guards against loops.

Top module: `prd_chain_walker`

## Requirements
- R1: A descriptor at byte address P is read as four little-endian words at P, P+4, P+8 and P+12, every read address being word aligned. Word P is the buffer address and goes to `brq_addr_o` unchanged. Word P+4 is the length in 8-byte units and goes to `brq_units_o` unchanged. In word P+8, bits [7:0] are the flags byte and bits [15:8] are the mode byte. Word P+12 is the next-descriptor pointer.
- R2: Flags bit 5 drives `brq_write_o` (1 = toward the disk). Flags bit 4 drives `brq_order_o`. Only the low four bits of the mode byte reach `brq_mode_o`; its upper four bits have no effect.
- R3: After a descriptor that is not last, the next fetch starts at that descriptor's next pointer, wherever that pointer lies. Descriptors need not be adjacent or in ascending order.
- R4: Flags bit 7 marks the last descriptor. The walk ends after that descriptor's burst with `done_o` and `err_o` = 0. Its next pointer is ignored and may be zero.
- R5: A descriptor whose length word is zero issues no burst, and the walk carries on. No burst is ever presented with zero units.
- R6: A non-last descriptor whose next pointer has bits [2:0] not all zero still issues its own burst. The walk then ends with `err_o` = 1 and fetches nothing further.
- R7: A start pointer with bits [2:0] not all zero is refused. The block issues no memory read and no burst, and `done_o` rises on the next cycle with `err_o` = 1.
- R8: A walk may process at most MAX_ENTRIES (default 256) descriptors. If the MAX_ENTRIES-th descriptor is not last, the walk ends with `err_o` = 2 after that descriptor's burst. A chain whose last flag sits on exactly that descriptor ends with `err_o` = 0.
- R9: While `brq_valid_o` is high and `brq_ready_i` is low, the burst request and all its fields hold steady. A burst counts as issued on the cycle both are high.
- R10: A start pulse is ignored while `busy_o` is high. The running walk's bursts and result are unchanged.
- R11: During and after reset, `busy_o`, `done_o`, `mrd_valid_o` and `brq_valid_o` are low and `err_o` is 0.
- R12: `done_o` is high for exactly one cycle per walk, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse from the sequencer |
| start_ptr_i | input | 32 | Byte address of the first descriptor |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 2 | 0 ok, 1 misaligned pointer, 2 entry limit reached |
| mrd_valid_o | output | 1 | Descriptor word read request |
| mrd_ready_i | input | 1 | Read request accepted |
| mrd_addr_o | output | 32 | Byte address of the requested word |
| mrd_rvalid_i | input | 1 | Read data valid |
| mrd_rdata_i | input | 32 | Read data |
| brq_valid_o | output | 1 | Burst request valid |
| brq_ready_i | input | 1 | Burst request accepted |
| brq_addr_o | output | 32 | Buffer byte address |
| brq_units_o | output | 32 | Length in 8-byte units |
| brq_write_o | output | 1 | Direction, 1 = toward the disk |
| brq_order_o | output | 1 | Ordering hint from the descriptor |
| brq_mode_o | output | 4 | Per-descriptor transfer mode |

## Verification
The bench builds chains in a behavioural memory and goes after these corner cases.

- Zero-length entries inside a chain: a design that mishandled them would issue an empty burst or stop the walk early.
- A misaligned next pointer: a design that checked it before issuing the burst would lose that entry's data, and one that checked it too late would fetch from a bad address.
- A chain of exactly the limit length, and a chain one entry longer: an off-by-one in the entry counter would either reject a legal chain or let a runaway chain take one extra burst.
- A self-referencing descriptor, to show the loop guard ends the walk.
- A stalling burst consumer: it would expose request fields that move while the request waits.
- A start pulse in mid-walk: a design that accepted it would redirect the walk.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;
  localparam int unsigned PTR_W   = 32;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned DESC_WORDS = 4;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned ALIGN_BITS = 3;

  // flag byte bit positions, decoded downstream
  localparam int unsigned FLG_ORDER = 4;
  localparam int unsigned FLG_WRITE = 5;
  localparam int unsigned FLG_LAST  = 7;

  typedef enum logic [1:0] {
    WERR_NONE  = 2'd0,
    WERR_ALIGN = 2'd1,
    WERR_LIMIT = 2'd2
  } werr_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_FETCH,
    WS_ISSUE,
    WS_STEP
  } wstate_e;

  typedef struct packed {
    logic [PTR_W-1:0]  buf_addr;
    logic [WORD_W-1:0] units;
    logic              write;
    logic              order;
    logic              last;
    logic [MODE_W-1:0] mode;
    logic [PTR_W-1:0]  next;
  } prd_dec_t;
endpackage

// File: rtl/prd_fetch.sv
module prd_fetch
  import prd_walk_pkg::*;
#(
  parameter int unsigned WORDS = DESC_WORDS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic [PTR_W-1:0]             base_i,
  output logic                         mrd_valid_o,
  input  logic                         mrd_ready_i,
  output logic [PTR_W-1:0]             mrd_addr_o,
  input  logic                         mrd_rvalid_i,
  input  logic [WORD_W-1:0]            mrd_rdata_i,
  output logic [WORDS-1:0][WORD_W-1:0] words_o,
  output logic                         words_valid_o
);
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORDS - 1);

  logic             active_q, pend_q;
  logic [IDX_W-1:0] idx_q;
  logic [PTR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q      <= 1'b0;
      pend_q        <= 1'b0;
      idx_q         <= '0;
      base_q        <= '0;
      words_o       <= '0;
      words_valid_o <= 1'b0;
    end else begin
      words_valid_o <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        pend_q   <= 1'b0;
        idx_q    <= '0;
        base_q   <= base_i;
      end else if (active_q) begin
        if (!pend_q && mrd_ready_i) begin
          pend_q <= 1'b1;
        end else if (pend_q && mrd_rvalid_i) begin
          words_o[idx_q] <= mrd_rdata_i;
          pend_q         <= 1'b0;
          if (idx_q == IDX_LAST) begin
            active_q      <= 1'b0;
            words_valid_o <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign mrd_valid_o = active_q && !pend_q;
  assign mrd_addr_o  = base_q + (PTR_W'(idx_q) << 2);

  assert_read_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_valid_o |-> (mrd_addr_o[1:0] == 2'b00));

  assert_rvalid_expected_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_rvalid_i |-> pend_q);
endmodule

// File: rtl/prd_decode.sv
module prd_decode
  import prd_walk_pkg::*;
(
  input  logic [DESC_WORDS-1:0][WORD_W-1:0] words_i,
  output prd_dec_t                          dec_o
);
  logic [7:0] flags, mode_byte;
  logic       unused_bits;

  assign flags     = words_i[2][7:0];
  assign mode_byte = words_i[2][15:8];

  always_comb begin
    dec_o.buf_addr = words_i[0];
    dec_o.units    = words_i[1];
    dec_o.order    = flags[FLG_ORDER];
    dec_o.write    = flags[FLG_WRITE];
    dec_o.last     = flags[FLG_LAST];
    dec_o.mode     = mode_byte[MODE_W-1:0];
    dec_o.next     = words_i[3];
  end

  assign unused_bits = ^{words_i[2][31:16], mode_byte[7:MODE_W], flags[6], flags[3:0]};
endmodule

// File: rtl/prd_hop_limit.sv
module prd_hop_limit #(
  parameter int unsigned MAX_ENTRIES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ENTRIES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (inc_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == LIMIT);

  assert_hop_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/prd_chain_walker.sv
module prd_chain_walker
  import prd_walk_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       start_ptr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic              mrd_valid_o,
  input  logic              mrd_ready_i,
  output logic [31:0]       mrd_addr_o,
  input  logic              mrd_rvalid_i,
  input  logic [31:0]       mrd_rdata_i,
  output logic              brq_valid_o,
  input  logic              brq_ready_i,
  output logic [31:0]       brq_addr_o,
  output logic [31:0]       brq_units_o,
  output logic              brq_write_o,
  output logic              brq_order_o,
  output logic [3:0]        brq_mode_o
);
  wstate_e state_q;
  werr_e   err_q;
  logic    done_q;

  logic [DESC_WORDS-1:0][WORD_W-1:0] words;
  logic             words_valid;
  prd_dec_t         dec;
  logic             fetch_go;
  logic [PTR_W-1:0] fetch_base;
  logic             at_limit;
  logic             start_ok, next_ok;

  assign start_ok = (start_ptr_i[ALIGN_BITS-1:0] == '0);
  assign next_ok  = (dec.next[ALIGN_BITS-1:0] == '0);

  always_comb begin
    fetch_go   = 1'b0;
    fetch_base = start_ptr_i;
    if (state_q == WS_IDLE) begin
      fetch_go = start_i && start_ok;
    end else if (state_q == WS_STEP) begin
      fetch_go   = !dec.last && next_ok && !at_limit;
      fetch_base = dec.next;
    end
  end

  prd_fetch u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .go_i          (fetch_go),
    .base_i        (fetch_base),
    .mrd_valid_o   (mrd_valid_o),
    .mrd_ready_i   (mrd_ready_i),
    .mrd_addr_o    (mrd_addr_o),
    .mrd_rvalid_i  (mrd_rvalid_i),
    .mrd_rdata_i   (mrd_rdata_i),
    .words_o       (words),
    .words_valid_o (words_valid)
  );

  prd_decode u_decode (
    .words_i (words),
    .dec_o   (dec)
  );

  prd_hop_limit #(.MAX_ENTRIES(MAX_ENTRIES)) u_hops (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (state_q == WS_IDLE),
    .inc_i      (words_valid),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      err_q   <= WERR_NONE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: if (start_i) begin
          if (start_ok) begin
            state_q <= WS_FETCH;
            err_q   <= WERR_NONE;
          end else begin
            done_q <= 1'b1;
            err_q  <= WERR_ALIGN;
          end
        end
        WS_FETCH: if (words_valid) begin
          state_q <= (dec.units == '0) ? WS_STEP : WS_ISSUE;
        end
        WS_ISSUE: if (brq_ready_i) state_q <= WS_STEP;
        WS_STEP: begin
          if (dec.last) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
          end else if (!next_ok) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
            err_q   <= WERR_ALIGN;
          end else if (at_limit) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
            err_q   <= WERR_LIMIT;
          end else begin
            state_q <= WS_FETCH;
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != WS_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign brq_valid_o = (state_q == WS_ISSUE);
  assign brq_addr_o  = dec.buf_addr;
  assign brq_units_o = dec.units;
  assign brq_write_o = dec.write;
  assign brq_order_o = dec.order;
  assign brq_mode_o  = dec.mode;

  assert_burst_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brq_valid_o && !brq_ready_i) |=>
      (brq_valid_o && $stable(brq_addr_o) && $stable(brq_units_o) &&
       $stable(brq_write_o) && $stable(brq_order_o) && $stable(brq_mode_o)));

  assert_no_empty_burst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brq_valid_o |-> (brq_units_o != '0));

  assert_burst_excl_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brq_valid_o |-> !mrd_valid_o);

  assert_done_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !brq_valid_o && !mrd_valid_o));

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/prd_chain_walker_tb.sv
module prd_chain_walker_tb;
  localparam int MAXE = 256;
  localparam int LOGN = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        busy, done;
  logic [1:0]  err;
  logic        mrd_valid, mrd_rvalid;
  logic [31:0] mrd_addr, mrd_rdata;
  logic        brq_valid, brq_ready, brq_write, brq_order;
  logic [31:0] brq_addr, brq_units;
  logic [3:0]  brq_mode;
  logic        stall_mode = 1'b0;
  logic        tog = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int nb = 0;
  int rd_cnt = 0;

  logic [31:0] mem [0:4095];
  logic [31:0] log_addr [0:LOGN-1];
  logic [31:0] log_units [0:LOGN-1];
  logic [5:0]  log_misc [0:LOGN-1];

  always #5 clk = ~clk;

  prd_chain_walker #(.MAX_ENTRIES(MAXE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_ptr_i(start_ptr),
    .busy_o(busy), .done_o(done), .err_o(err),
    .mrd_valid_o(mrd_valid), .mrd_ready_i(1'b1), .mrd_addr_o(mrd_addr),
    .mrd_rvalid_i(mrd_rvalid), .mrd_rdata_i(mrd_rdata),
    .brq_valid_o(brq_valid), .brq_ready_i(brq_ready), .brq_addr_o(brq_addr),
    .brq_units_o(brq_units), .brq_write_o(brq_write), .brq_order_o(brq_order),
    .brq_mode_o(brq_mode)
  );

  assign brq_ready = !stall_mode || tog;

  always @(posedge clk) begin
    tog        <= ~tog;
    cycles     <= cycles + 1;
    mrd_rvalid <= mrd_valid;
    mrd_rdata  <= mem[mrd_addr[13:2]];
    if (mrd_valid) rd_cnt <= rd_cnt + 1;
    if (brq_valid && brq_ready) begin
      log_addr[nb % LOGN]  <= brq_addr;
      log_units[nb % LOGN] <= brq_units;
      log_misc[nb % LOGN]  <= {brq_write, brq_order, brq_mode};
      nb <= nb + 1;
    end
  end

  typedef struct packed {
    logic [8:0]  n;
    logic [7:0]  zmask;
    logic [7:0]  wmask;
    logic [15:0] base;
    logic [15:0] stride;
    logic [8:0]  exp_b;
    logic        stall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{9'd1, 8'h00, 8'h00, 16'h0100, 16'd16, 9'd1, 1'b0},
    '{9'd4, 8'h00, 8'h05, 16'h0200, 16'd32, 9'd4, 1'b1},
    '{9'd5, 8'h06, 8'h00, 16'h0400, 16'd48, 9'd3, 1'b0},
    '{9'd3, 8'h07, 8'h07, 16'h0600, 16'd16, 9'd0, 1'b0},
    '{9'd8, 8'h81, 8'hF0, 16'h0800, 16'd64, 9'd6, 1'b1}
  };

  function automatic logic [31:0] e_buf(int i, logic [15:0] base);
    return 32'hA000_0000 + (32'(base) << 8) + 32'(i) * 32'h40;
  endfunction
  function automatic logic [31:0] e_units(int i, logic [7:0] zm);
    return (i < 8 && zm[i]) ? 32'd0 : 32'(i + 1);
  endfunction
  function automatic logic [5:0] e_misc(int i, logic [7:0] wm);
    logic w;
    logic [3:0] m;
    w = (i < 8) ? wm[i] : 1'b0;
    m = 4'((i + 3) & 15);
    return {w, i[0], m};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // last_final: last flag on final entry; bad_idx: entry with misaligned next (-1 none)
  task automatic build_chain(input logic [15:0] base, input logic [15:0] stride, input int n,
                             input logic [7:0] zm, input logic [7:0] wm,
                             input bit last_final, input int bad_idx);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a, nx;
      logic [5:0]  misc;
      logic [7:0]  flg;
      bit          lst;
      a    = 32'(base) + 32'(i) * 32'(stride);
      lst  = last_final && (i == n - 1);
      nx   = (i == n - 1) ? (lst ? 32'd0 : 32'(base)) : a + 32'(stride);
      if (i == bad_idx) nx = a + 32'(stride) + 32'd4;
      misc = e_misc(i, wm);
      flg  = {lst, 1'b0, misc[5], misc[4], 4'h0};
      mem[a[13:2]]     = e_buf(i, base);
      mem[a[13:2] + 1] = e_units(i, zm);
      mem[a[13:2] + 2] = {8'h00, 8'h55, 4'hA, misc[3:0], flg};
      mem[a[13:2] + 3] = nx;
    end
  endtask

  task automatic run_walk(input logic [31:0] ptr, input bit stl, output int nb0, output int rd0);
    nb0 = nb;
    rd0 = rd_cnt;
    stall_mode = stl;
    @(negedge clk);
    start = 1'b1;
    start_ptr = ptr;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_bursts(input string req, input logic [15:0] base, input int n,
                              input logic [7:0] zm, input logic [7:0] wm, input int nb0);
    int k = 0;
    for (int i = 0; i < n; i++) begin
      if (e_units(i, zm) != 0) begin
        int s = (nb0 + k) % LOGN;
        check(log_addr[s] == e_buf(i, base) && log_units[s] == e_units(i, zm) &&
              log_misc[s] == e_misc(i, wm), req,
              {log_addr[s], log_units[s][25:0], log_misc[s]},
              {e_buf(i, base), e_units(i, zm)[25:0], e_misc(i, wm)});
        k++;
      end
    end
  endtask

  initial begin
    while (cycles < 190000) @(negedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected done", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int nb0, rd0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, done, mrd_valid, brq_valid, err} == 6'd0, "R11 in reset",
          {busy, done, mrd_valid, brq_valid, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, mrd_valid, brq_valid, err} == 6'd0, "R11 after reset",
          {busy, done, mrd_valid, brq_valid, err}, 0);

    // vector table: R1 R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      build_chain(VECS[v].base, VECS[v].stride, int'(VECS[v].n), VECS[v].zmask,
                  VECS[v].wmask, 1'b1, -1);
      run_walk(32'(VECS[v].base), VECS[v].stall, nb0, rd0);
      check(nb - nb0 == int'(VECS[v].exp_b), "R5 burst count", nb - nb0, VECS[v].exp_b);
      check(err == 2'd0, "R4 clean end", err, 0);
      check(rd_cnt - rd0 == 4 * int'(VECS[v].n), "R3 descriptor reads", rd_cnt - rd0, 4 * VECS[v].n);
      check_bursts("R1 R2 burst fields", VECS[v].base, int'(VECS[v].n), VECS[v].zmask,
                   VECS[v].wmask, nb0);
    end
    stall_mode = 1'b0;

    // R7 misaligned start
    run_walk(32'h0000_0104, 1'b0, nb0, rd0);
    check(err == 2'd1, "R7 start align err", err, 1);
    check(nb == nb0 && rd_cnt == rd0, "R7 no traffic", (nb - nb0) + (rd_cnt - rd0), 0);

    // R12 done pulse width and busy timing
    build_chain(16'h0C00, 16'd16, 2, 8'h00, 8'h00, 1'b1, -1);
    begin
      int hi = 0;
      int busy_at_done = 0;
      @(negedge clk);
      start = 1'b1; start_ptr = 32'h0C00;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R12 busy after start", busy, 1);
      for (int c = 0; c < 100; c++) begin
        if (done) begin hi++; busy_at_done += int'(busy); end
        @(negedge clk);
      end
      check(hi == 1 && busy_at_done == 0, "R12 done pulse", {hi[15:0], busy_at_done[15:0]}, 32'h0001_0000);
    end

    // R6 misaligned next pointer on entry 1 of 3
    build_chain(16'h0D00, 16'd16, 3, 8'h00, 8'h00, 1'b1, 1);
    run_walk(32'h0D00, 1'b0, nb0, rd0);
    check(err == 2'd1, "R6 next align err", err, 1);
    check(nb - nb0 == 2, "R6 burst before abort", nb - nb0, 2);
    check(rd_cnt - rd0 == 8, "R6 no further fetch", rd_cnt - rd0, 8);

    // R4 last entry with misaligned next is still a clean end
    build_chain(16'h0E00, 16'd16, 1, 8'h00, 8'h00, 1'b1, -1);
    mem[(32'h0E00 >> 2) + 3] = 32'h0000_0E05;
    run_walk(32'h0E00, 1'b0, nb0, rd0);
    check(err == 2'd0 && nb - nb0 == 1, "R4 next ignored on last", {err, 8'(nb - nb0)}, 10'h001);

    // R8 exactly MAXE entries ending cleanly
    build_chain(16'h1000, 16'd16, MAXE, 8'h00, 8'h00, 1'b1, -1);
    run_walk(32'h1000, 1'b0, nb0, rd0);
    check(err == 2'd0, "R8 limit-length chain ok", err, 0);
    check(nb - nb0 == MAXE, "R8 limit-length bursts", nb - nb0, MAXE);

    // R8 MAXE+1 entries: limit error after MAXE bursts
    build_chain(16'h1000, 16'd16, MAXE + 1, 8'h00, 8'h00, 1'b1, -1);
    run_walk(32'h1000, 1'b0, nb0, rd0);
    check(err == 2'd2, "R8 over-limit err", err, 2);
    check(nb - nb0 == MAXE, "R8 over-limit bursts", nb - nb0, MAXE);

    // R8 self-loop
    build_chain(16'h3000, 16'd16, 1, 8'h00, 8'h00, 1'b0, -1);
    run_walk(32'h3000, 1'b0, nb0, rd0);
    check(err == 2'd2 && nb - nb0 == MAXE, "R8 self loop", {err, 16'(nb - nb0)}, {2'd2, 16'(MAXE)});

    // R10 start ignored while busy
    build_chain(16'h0200, 16'd32, 4, 8'h00, 8'h05, 1'b1, -1);
    nb0 = nb;
    @(negedge clk);
    start = 1'b1; start_ptr = 32'h0200;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; start_ptr = 32'h0100;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 still busy", busy, 1);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(nb - nb0 == 4 && err == 2'd0, "R10 walk unchanged", {err, 8'(nb - nb0)}, 10'h004);
    check_bursts("R10 bursts unchanged", 16'h0200, 4, 8'h00, 8'h05, nb0);
    repeat (4) @(negedge clk);
    check(!busy && nb - nb0 == 4, "R10 no restart", {busy, 8'(nb - nb0)}, 9'h004);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule